// File: doc/BRIEF.md
# Weight-Stationary Systolic Compute Cell

This block is one tile of a two-dimensional matrix multiplier. Each tile holds one weight and does one multiply-add per clock. Activations move from west to east, and partial sums move from north to south. All values are signed 16-bit fixed point with eight fraction bits, so the top bit is the sign, the next seven bits are the integer part, and the low eight bits are the fraction. The tile multiplies the incoming activation by its live weight, adds the partial sum that arrives from the north, and registers the result toward the south.

Weights move down a column while the array is computing. A load strobe from the north writes the arriving weight into a shadow register. The strobe and the weight are also passed south one cycle later, so the column fills over successive cycles. A swap strobe from the west moves the shadow weight into the live register. The swap takes effect in the same cycle: the multiply-add in that cycle already uses the new weight. The strobe is then registered eastward, so the swap moves diagonally across the array.

A per-tile enable turns a tile into a pass-through for columns that the current matrix does not use. A valid flag marks the cycles that carry real data.

Top module: `systolic_cell`

## Requirements
- R1: The product of activation and weight is the full 32-bit signed product, rounded to nearest by adding 0x80 and then shifting right arithmetically by 8. For example, raw 0x0080 × raw 0x0001 gives 1, raw 0x007F × raw 0x0001 gives 0, and raw −129 × raw 1 gives −1.
- R2: A rounded product outside the 16-bit signed range is clamped to 0x7FFF if positive or to 0x8000 if negative.
- R3: The sum of the product and the north partial sum is clamped to 0x7FFF or 0x8000 on signed overflow.
- R4: When valid and enable are both high, the saturated multiply-add result appears on the south partial sum after the next rising edge, and the activation appears on the east output after the same edge.
- R5: When load is high, the north weight is written into the shadow register, and the live weight is unchanged. The weight and the load strobe appear on the south outputs one edge later.
- R6: When swap is high, the multiply-add in that same cycle uses the shadow weight as it stood at the start of the cycle. That weight stays live afterwards until the next swap.
- R7: The east swap output is the swap input delayed by one edge.
- R8: When valid is low, the south partial sum and the east activation are 0 after the next edge, and the east valid is low.
- R9: When valid is high and enable is low, the south partial sum takes the north partial sum unchanged. The east activation and east valid still forward the inputs.
- R10: A synchronous active-high reset clears both weight registers and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| west_act_i | input | DATA_W | Activation from the west |
| west_vld_i | input | 1 | Activation valid |
| west_swap_i | input | 1 | Swap the shadow weight into the live register |
| west_en_i | input | 1 | Tile enable |
| north_psum_i | input | DATA_W | Partial sum from the north |
| north_wt_i | input | DATA_W | Weight arriving from the north |
| north_load_i | input | 1 | Capture the north weight into the shadow register |
| south_psum_o | output | DATA_W | Registered partial sum going south |
| south_wt_o | output | DATA_W | Registered weight going south |
| south_load_o | output | 1 | Registered load strobe going south |
| east_act_o | output | DATA_W | Registered activation going east |
| east_vld_o | output | 1 | Registered valid going east |
| east_swap_o | output | 1 | Registered swap strobe going east |

## Verification
The hardest case to reach from the ports is a swap in the same cycle as valid data, because the live weight is never visible on its own. The bench loads a shadow weight first and confirms that a computation made before the swap still uses the old weight. It then raises swap together with valid data, so that the south partial sum shows which weight the multiply-add used. A later reset, followed by a swap with no new load, shows through the multiply-add result that the shadow register was cleared as well.

// File: rtl/sc_pkg.sv
package sc_pkg;
  // Source chosen for the south partial-sum register
  typedef enum logic [1:0] {
    PSUM_IDLE = 2'd0,
    PSUM_MAC  = 2'd1,
    PSUM_PASS = 2'd2
  } psum_sel_e;
endpackage

// File: rtl/sc_fxp_mul.sv
module sc_fxp_mul #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic signed [DATA_W-1:0] a,
  input  logic signed [DATA_W-1:0] b,
  output logic signed [DATA_W-1:0] y
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int SH_W   = PROD_W - FRAC_W;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);
  localparam logic signed [SH_W-1:0]   MAXV = SH_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [SH_W-1:0]   MINV = -MAXV - SH_W'(1);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rnd;
  logic signed [SH_W-1:0]   shifted;

  always_comb begin
    prod    = a * b;
    rnd     = prod + HALF;
    shifted = rnd[PROD_W-1:FRAC_W];
    if (shifted > MAXV)      y = {1'b0, {(DATA_W-1){1'b1}}};
    else if (shifted < MINV) y = {1'b1, {(DATA_W-1){1'b0}}};
    else                     y = shifted[DATA_W-1:0];
  end

  // R2: a clamped result keeps the sign of the true product
  always_comb begin
    if ((a != '0) && (b != '0) && (a[DATA_W-1] == b[DATA_W-1]))
      a_r2_pos_sign: assert (!y[DATA_W-1]);
  end
endmodule

// File: rtl/sc_fxp_add.sv
module sc_fxp_add #(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] a,
  input  logic signed [DATA_W-1:0] b,
  output logic signed [DATA_W-1:0] y
);
  logic signed [DATA_W:0] wide;

  always_comb begin
    wide = {a[DATA_W-1], a} + {b[DATA_W-1], b};
    if (wide[DATA_W] != wide[DATA_W-1])
      y = wide[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    else
      y = wide[DATA_W-1:0];
  end

  // R3: no wrap-around between two operands of the same sign
  always_comb begin
    if (!a[DATA_W-1] && !b[DATA_W-1]) a_r3_no_pos_wrap: assert (!y[DATA_W-1]);
    if (a[DATA_W-1] && b[DATA_W-1])   a_r3_no_neg_wrap: assert (y[DATA_W-1]);
  end
endmodule

// File: rtl/sc_weight_bank.sv
module sc_weight_bank #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wt_in,
  input  logic              swap,
  output logic [DATA_W-1:0] wt_live
);
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (load) shadow_q <= wt_in;
      if (swap) active_q <= shadow_q;
    end
  end

  // Same-cycle swap: the shadow value is forwarded straight to the MAC
  assign wt_live = swap ? shadow_q : active_q;

  a_r5_shadow_capture: assert property (@(posedge clk) disable iff (rst)
    load |=> shadow_q == $past(wt_in));
  a_r6_swap_commit: assert property (@(posedge clk) disable iff (rst)
    swap |=> active_q == $past(shadow_q));
  a_r6_active_hold: assert property (@(posedge clk) disable iff (rst)
    !swap |=> $stable(active_q));
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (shadow_q == '0) && (active_q == '0));
endmodule

// File: rtl/systolic_cell.sv
module systolic_cell #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] west_act_i,
  input  logic              west_vld_i,
  input  logic              west_swap_i,
  input  logic              west_en_i,
  input  logic [DATA_W-1:0] north_psum_i,
  input  logic [DATA_W-1:0] north_wt_i,
  input  logic              north_load_i,
  output logic [DATA_W-1:0] south_psum_o,
  output logic [DATA_W-1:0] south_wt_o,
  output logic              south_load_o,
  output logic [DATA_W-1:0] east_act_o,
  output logic              east_vld_o,
  output logic              east_swap_o
);
  import sc_pkg::*;

  logic [DATA_W-1:0] wt_live;
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] mac;
  psum_sel_e         sel;

  sc_weight_bank #(.DATA_W(DATA_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .load   (north_load_i),
    .wt_in  (north_wt_i),
    .swap   (west_swap_i),
    .wt_live(wt_live)
  );

  sc_fxp_mul #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mul (
    .a(west_act_i),
    .b(wt_live),
    .y(prod)
  );

  sc_fxp_add #(.DATA_W(DATA_W)) u_add (
    .a(prod),
    .b(north_psum_i),
    .y(mac)
  );

  always_comb begin
    if (!west_vld_i)     sel = PSUM_IDLE;
    else if (west_en_i)  sel = PSUM_MAC;
    else                 sel = PSUM_PASS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      south_psum_o <= '0;
      south_wt_o   <= '0;
      south_load_o <= 1'b0;
      east_act_o   <= '0;
      east_vld_o   <= 1'b0;
      east_swap_o  <= 1'b0;
    end else begin
      case (sel)
        PSUM_MAC:  south_psum_o <= mac;
        PSUM_PASS: south_psum_o <= north_psum_i;
        default:   south_psum_o <= '0;
      endcase
      east_act_o   <= west_vld_i ? west_act_i : '0;
      east_vld_o   <= west_vld_i;
      east_swap_o  <= west_swap_i;
      south_wt_o   <= north_wt_i;
      south_load_o <= north_load_i;
    end
  end

  a_r4_act_forward: assert property (@(posedge clk) disable iff (rst)
    west_vld_i |=> east_act_o == $past(west_act_i));
  a_r5_wt_forward: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (south_wt_o == $past(north_wt_i)) && (south_load_o == $past(north_load_i)));
  a_r7_swap_token: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> east_swap_o == $past(west_swap_i));
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !west_vld_i |=> (south_psum_o == '0) && (east_act_o == '0) && !east_vld_o);
  a_r9_bypass: assert property (@(posedge clk) disable iff (rst)
    (west_vld_i && !west_en_i) |=> (south_psum_o == $past(north_psum_i)) && east_vld_o);
  a_r10_outputs_clear: assert property (@(posedge clk)
    rst |=> (south_psum_o == '0) && (east_act_o == '0) && !east_vld_o && !east_swap_o
            && !south_load_o && (south_wt_o == '0));
endmodule

// File: tb/test_systolic_cell.sv
module test_systolic_cell;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] act = '0, psum = '0, wt = '0;
  logic        vld = 1'b0, sw = 1'b0, en = 1'b0, ld = 1'b0;
  logic [15:0] s_psum, s_wt, e_act;
  logic        s_ld, e_vld, e_sw;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  systolic_cell i_systolic_cell (
    .clk(clk), .rst(rst),
    .west_act_i(act), .west_vld_i(vld), .west_swap_i(sw), .west_en_i(en),
    .north_psum_i(psum), .north_wt_i(wt), .north_load_i(ld),
    .south_psum_o(s_psum), .south_wt_o(s_wt), .south_load_o(s_ld),
    .east_act_o(e_act), .east_vld_o(e_vld), .east_swap_o(e_sw)
  );

  function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    longint pa, pb, p;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    p  = (pa * pb + 128) >>> 8;
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return p[15:0];
  endfunction

  function automatic logic [15:0] ref_add(input logic [15:0] a, input logic [15:0] b);
    longint s;
    s = longint'($signed(a)) + longint'($signed(b));
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return s[15:0];
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Apply one cycle of inputs at a falling edge; outputs are read at the next falling edge
  task automatic cyc(input logic v, input logic e, input logic s, input logic l,
                     input logic [15:0] a, input logic [15:0] p, input logic [15:0] w);
    vld = v; en = e; sw = s; ld = l; act = a; psum = p; wt = w;
    @(negedge clk);
  endtask

  task automatic load_and_swap(input logic [15:0] w);
    cyc(0, 1, 0, 1, 16'h0, 16'h0, w);
    cyc(0, 1, 1, 0, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic t_reset;
    chk("R10 psum", s_psum, 16'h0);
    chk("R10 act", e_act, 16'h0);
    chk("R10 flags", {10'b0, s_ld, e_vld, e_sw, 3'b0}, 16'h0);
    chk("R10 wt", s_wt, 16'h0);
  endtask

  task automatic t_load_and_swap;
    cyc(0, 1, 0, 1, 16'h0, 16'h0, 16'h0200);
    chk("R5 wt south", s_wt, 16'h0200);
    chk("R5 load south", {15'b0, s_ld}, 16'h1);
    cyc(1, 1, 0, 0, 16'h0180, 16'h0100, 16'h0);
    chk("R5 live unchanged", s_psum, 16'h0100);
    chk("R5 load south low", {15'b0, s_ld}, 16'h0);
    cyc(1, 1, 1, 0, 16'h0180, 16'h0100, 16'h0);
    chk("R6 same-cycle swap", s_psum, 16'h0400);
    chk("R7 swap east", {15'b0, e_sw}, 16'h1);
    chk("R4 act east", e_act, 16'h0180);
    cyc(1, 1, 0, 0, 16'hFF00, 16'h0000, 16'h0);
    chk("R6 weight stays", s_psum, 16'hFE00);
    chk("R7 swap east low", {15'b0, e_sw}, 16'h0);
  endtask

  task automatic t_rounding;
    logic [15:0] acts [4] = '{16'h0080, 16'h007F, 16'hFF80, 16'hFF7F};
    logic [15:0] exps [4] = '{16'h0001, 16'h0000, 16'h0000, 16'hFFFF};
    load_and_swap(16'h0001);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 1, 0, 0, acts[i], 16'h0, 16'h0);
      chk("R1 rounding", s_psum, exps[i]);
      chk("R1 model", s_psum, ref_mul(acts[i], 16'h0001));
    end
  endtask

  task automatic t_mul_sat;
    load_and_swap(16'h7FFF);
    cyc(1, 1, 0, 0, 16'h7FFF, 16'h0, 16'h0);
    chk("R2 pos clamp", s_psum, 16'h7FFF);
    cyc(1, 1, 0, 0, 16'h8000, 16'h0, 16'h0);
    chk("R2 neg clamp", s_psum, 16'h8000);
    cyc(1, 1, 0, 0, 16'h0123, 16'h0042, 16'h0);
    chk("R4 mac", s_psum, ref_add(ref_mul(16'h0123, 16'h7FFF), 16'h0042));
  endtask

  task automatic t_add_sat;
    load_and_swap(16'h0100);
    cyc(1, 1, 0, 0, 16'h7000, 16'h7000, 16'h0);
    chk("R3 pos clamp", s_psum, 16'h7FFF);
    cyc(1, 1, 0, 0, 16'h9000, 16'h9000, 16'h0);
    chk("R3 neg clamp", s_psum, 16'h8000);
    cyc(1, 1, 0, 0, 16'h0250, 16'hFF10, 16'h0);
    chk("R3 no clamp", s_psum, ref_add(16'h0250, 16'hFF10));
  endtask

  task automatic t_invalid;
    cyc(0, 1, 0, 0, 16'h1234, 16'h5678, 16'h0);
    chk("R8 psum zero", s_psum, 16'h0);
    chk("R8 act zero", e_act, 16'h0);
    chk("R8 vld low", {15'b0, e_vld}, 16'h0);
  endtask

  task automatic t_disabled;
    cyc(1, 0, 0, 0, 16'h0300, 16'h1357, 16'h0);
    chk("R9 psum pass", s_psum, 16'h1357);
    chk("R9 act fwd", e_act, 16'h0300);
    chk("R9 vld fwd", {15'b0, e_vld}, 16'h1);
  endtask

  task automatic t_mid_reset;
    cyc(1, 1, 1, 1, 16'h0100, 16'h0011, 16'h0500);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    vld = 0; sw = 0; ld = 0; act = '0; psum = '0; wt = '0;
    t_reset();
    cyc(1, 1, 0, 0, 16'h0100, 16'h0005, 16'h0);
    chk("R10 live cleared", s_psum, 16'h0005);
    cyc(1, 1, 1, 0, 16'h0100, 16'h0005, 16'h0);
    chk("R10 shadow cleared", s_psum, 16'h0005);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_and_swap();
    t_rounding();
    t_mul_sat();
    t_add_sat();
    t_invalid();
    t_disabled();
    t_mid_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule